// File: doc/BRIEF.md
# Quadrature Weighted Drive Modulator Bank

This block turns one shared sinusoid into several drive waveforms. Each waveform runs at the same frequency, and each has its own amplitude and phase. A common generator supplies matching signed cosine and sine samples with a valid strobe. Every channel multiplies the cosine sample by its in-phase weight A and the sine sample by its quadrature weight B. It then adds the two products and scales the sum to a signed 16-bit word for a digital-to-analog converter. The output is A·cos(ωt) + B·sin(ωt). Its amplitude is sqrt(A²+B²), and its phase follows from the ratio of the two weights, so the two weights move amplitude and phase independently.

Software writes a new weight pair into a channel's shadow register with a per-channel load strobe. Both weights move into service together at the next accepted sample, so no output word is ever built from one old weight and one new weight. All channels share one two-stage pipeline. Their output words therefore leave together, under a single valid flag.

Top module: `quad_mod_bank`

## Requirements
- R1: For every valid sample, each channel's output equals the 35-bit signed sum A·cos + B·sin, shifted right by 17 with rounding to nearest, where ties round toward positive infinity (add 2^16, then arithmetic shift right by 17). A zero sample pair gives a zero output.
- R2: When the rounded result lies above 32767, the output is 32767. When it lies below -32768, the output is -32768.
- R3: Each channel uses only its own A and B, which are signed 16-bit fields at bits [16c+15:16c] of coef_a_i and coef_b_i. Its result appears at bits [16c+15:16c] of dac_data_o.
- R4: dac_valid_o is high exactly two clock edges after an edge at which smp_valid_i was high, and is low otherwise.
- R5: A weight pair captured at a load edge is used for the first valid sample at a later edge, and A and B change together. A sample accepted at the same edge as the load still uses the previous pair.
- R6: When a channel sees several loads with no valid sample between them, only the last pair is used.
- R7: After reset, dac_valid_o is low, every output word is zero, and every channel's weights are zero until its first load.
- R8: While dac_valid_o is low, dac_data_o holds its last value.
- R9: A load strobe on one channel leaves the weights of every other channel unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_valid_i | input | 1 | Shared cosine/sine sample valid |
| cos_i | input | 18 | Shared signed cosine sample |
| sin_i | input | 18 | Shared signed sine sample |
| coef_load_i | input | N_CH | Per-channel weight load strobe |
| coef_a_i | input | 16*N_CH | Packed signed in-phase weights |
| coef_b_i | input | 16*N_CH | Packed signed quadrature weights |
| dac_valid_o | output | 1 | Output words valid |
| dac_data_o | output | 16*N_CH | Packed signed output words |

## Verification
The bench targets the following corner cases and the failure each would expose:
- Extreme weights at both rails. A design that wraps instead of clamping would flip the sign of a near-full-scale output.
- A load that lands on the same edge as a sample, and a load placed between two samples. A design with no shadow register, or with its hand-over at the wrong edge, would emit one word built from mixed or early weights.
- Back-to-back loads. These expose a design that keeps the first pair instead of the last.
- Loads aimed at a single channel. These catch a strobe that leaks into its neighbours.
- Gaps in the valid stream. These expose a latency that is not fixed, or output words that drift while valid is low.
- Long random runs with random weights. These check the rounding at ties against a bench model of the scaled sum.

// File: rtl/quad_mod_pkg.sv
`timescale 1ns/1ps
package quad_mod_pkg;
  localparam int unsigned SMP_W_DEF  = 18;
  localparam int unsigned COEF_W_DEF = 16;
  localparam int unsigned DAC_W_DEF  = 16;
  localparam int unsigned N_CH_DEF   = 8;
endpackage

// File: rtl/quad_coef_buf.sv
`timescale 1ns/1ps
module quad_coef_buf #(
  parameter int unsigned COEF_W = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     load_i,
  input  logic signed [COEF_W-1:0] a_i,
  input  logic signed [COEF_W-1:0] b_i,
  input  logic                     smp_valid_i,
  output logic signed [COEF_W-1:0] eff_a_o,
  output logic signed [COEF_W-1:0] eff_b_o
);
  logic signed [COEF_W-1:0] act_a_q, act_b_q, sh_a_q, sh_b_q;
  logic                     pend_q;

  // pending shadow pair wins for the sample taken at this edge
  assign eff_a_o = pend_q ? sh_a_q : act_a_q;
  assign eff_b_o = pend_q ? sh_b_q : act_b_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_a_q <= '0;
      act_b_q <= '0;
      sh_a_q  <= '0;
      sh_b_q  <= '0;
      pend_q  <= 1'b0;
    end else begin
      if (smp_valid_i) begin
        act_a_q <= eff_a_o;
        act_b_q <= eff_b_o;
      end
      if (load_i) begin
        sh_a_q <= a_i;
        sh_b_q <= b_i;
        pend_q <= 1'b1;
      end else if (smp_valid_i) begin
        pend_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/quad_round_sat.sv
`timescale 1ns/1ps
module quad_round_sat #(
  parameter int unsigned IN_W  = 35,
  parameter int unsigned SHIFT = 17,
  parameter int unsigned OUT_W = 16
) (
  input  logic signed [IN_W-1:0]  sum_i,
  output logic signed [OUT_W-1:0] out_o
);
  localparam int unsigned W1 = IN_W + 1;
  localparam int unsigned UB = W1 - OUT_W + 1;
  localparam logic signed [W1-1:0]    HALF = W1'(1) << (SHIFT - 1);
  localparam logic signed [OUT_W-1:0] MAXV = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic signed [OUT_W-1:0] MINV = {1'b1, {(OUT_W-1){1'b0}}};

  logic signed [W1-1:0] ext, rnd, q;
  logic                 ovf;

  always_comb begin
    ext = {sum_i[IN_W-1], sum_i};
    rnd = ext + HALF;
    q   = rnd >>> SHIFT;
    ovf = (q[W1-1:OUT_W-1] != {UB{q[W1-1]}});
    if (ovf) out_o = q[W1-1] ? MINV : MAXV;
    else     out_o = q[OUT_W-1:0];
  end
endmodule

// File: rtl/quad_mac.sv
`timescale 1ns/1ps
module quad_mac #(
  parameter int unsigned SMP_W  = 18,
  parameter int unsigned COEF_W = 16,
  parameter int unsigned DAC_W  = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     en1_i,
  input  logic                     en2_i,
  input  logic signed [SMP_W-1:0]  cos_i,
  input  logic signed [SMP_W-1:0]  sin_i,
  input  logic signed [COEF_W-1:0] a_i,
  input  logic signed [COEF_W-1:0] b_i,
  output logic signed [DAC_W-1:0]  data_o
);
  localparam int unsigned PW = SMP_W + COEF_W;
  localparam int unsigned SW = PW + 1;

  logic signed [PW-1:0]    pa_q, pb_q;
  logic signed [SW-1:0]    sum;
  logic signed [DAC_W-1:0] rs_out, data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pa_q <= '0;
      pb_q <= '0;
    end else if (en1_i) begin
      pa_q <= PW'(cos_i) * PW'(a_i);
      pb_q <= PW'(sin_i) * PW'(b_i);
    end
  end

  assign sum = SW'(pa_q) + SW'(pb_q);

  quad_round_sat #(
    .IN_W (SW),
    .SHIFT(SMP_W - 1),
    .OUT_W(DAC_W)
  ) u_rs (
    .sum_i(sum),
    .out_o(rs_out)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    data_q <= '0;
    else if (en2_i) data_q <= rs_out;
  end

  assign data_o = data_q;
endmodule

// File: rtl/quad_mod_bank.sv
`timescale 1ns/1ps
module quad_mod_bank #(
  parameter int unsigned N_CH   = quad_mod_pkg::N_CH_DEF,
  parameter int unsigned SMP_W  = quad_mod_pkg::SMP_W_DEF,
  parameter int unsigned COEF_W = quad_mod_pkg::COEF_W_DEF,
  parameter int unsigned DAC_W  = quad_mod_pkg::DAC_W_DEF
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     smp_valid_i,
  input  logic [SMP_W-1:0]         cos_i,
  input  logic [SMP_W-1:0]         sin_i,
  input  logic [N_CH-1:0]          coef_load_i,
  input  logic [N_CH*COEF_W-1:0]   coef_a_i,
  input  logic [N_CH*COEF_W-1:0]   coef_b_i,
  output logic                     dac_valid_o,
  output logic [N_CH*DAC_W-1:0]    dac_data_o
);
  logic v1_q, v2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
    end else begin
      v1_q <= smp_valid_i;
      v2_q <= v1_q;
    end
  end

  assign dac_valid_o = v2_q;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic signed [COEF_W-1:0] eff_a, eff_b;
    logic signed [DAC_W-1:0]  ch_data;

    quad_coef_buf #(.COEF_W(COEF_W)) u_buf (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (coef_load_i[c]),
      .a_i        (coef_a_i[c*COEF_W +: COEF_W]),
      .b_i        (coef_b_i[c*COEF_W +: COEF_W]),
      .smp_valid_i(smp_valid_i),
      .eff_a_o    (eff_a),
      .eff_b_o    (eff_b)
    );

    quad_mac #(.SMP_W(SMP_W), .COEF_W(COEF_W), .DAC_W(DAC_W)) u_mac (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .en1_i (smp_valid_i),
      .en2_i (v1_q),
      .cos_i (cos_i),
      .sin_i (sin_i),
      .a_i   (eff_a),
      .b_i   (eff_b),
      .data_o(ch_data)
    );

    assign dac_data_o[c*DAC_W +: DAC_W] = ch_data;
  end
endmodule

// File: rtl/quad_mod_bank_chk.sv
`timescale 1ns/1ps
module quad_mod_bank_chk #(
  parameter int unsigned N_CH  = 8,
  parameter int unsigned SMP_W = 18,
  parameter int unsigned DAC_W = 16
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  smp_valid_i,
  input logic [SMP_W-1:0]      cos_i,
  input logic [SMP_W-1:0]      sin_i,
  input logic                  dac_valid_o,
  input logic [N_CH*DAC_W-1:0] dac_data_o
);
  logic [1:0] cyc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cyc_q <= '0;
    else if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
  end

  AST_RESET_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q == 2'd0) |-> (!dac_valid_o && dac_data_o == '0)); // R7

  AST_VALID_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 2'd2) |-> (dac_valid_o == $past(smp_valid_i, 2))); // R4

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 2'd1 && !dac_valid_o) |-> $stable(dac_data_o)); // R8

  AST_ZERO_INPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 2'd2 && $past(smp_valid_i, 2) && $past(cos_i, 2) == '0 &&
     $past(sin_i, 2) == '0) |-> (dac_data_o == '0)); // R1
endmodule

bind quad_mod_bank quad_mod_bank_chk #(
  .N_CH (N_CH),
  .SMP_W(SMP_W),
  .DAC_W(DAC_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .smp_valid_i(smp_valid_i),
  .cos_i      (cos_i),
  .sin_i      (sin_i),
  .dac_valid_o(dac_valid_o),
  .dac_data_o (dac_data_o)
);

// File: tb/quad_mod_bank_tb.sv
`timescale 1ns/1ps
module quad_mod_bank_tb;
  localparam int N = 8;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            smp_valid_i = 1'b0;
  logic [17:0]     cos_i = '0;
  logic [17:0]     sin_i = '0;
  logic [N-1:0]    coef_load_i = '0;
  logic [N*16-1:0] coef_a_i = '0;
  logic [N*16-1:0] coef_b_i = '0;
  logic            dac_valid_o;
  logic [N*16-1:0] dac_data_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int m_act_a[N], m_act_b[N], m_sh_a[N], m_sh_b[N];
  bit m_pend[N];
  int na[N], nb[N];
  int d1[N], d2[N], hold[N], cur[N];
  bit d1_v = 1'b0, d2_v = 1'b0;

  always #10 clk_i = ~clk_i;

  quad_mod_bank u_dut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .smp_valid_i(smp_valid_i),
    .cos_i      (cos_i),
    .sin_i      (sin_i),
    .coef_load_i(coef_load_i),
    .coef_a_i   (coef_a_i),
    .coef_b_i   (coef_b_i),
    .dac_valid_o(dac_valid_o),
    .dac_data_o (dac_data_o)
  );

  function automatic int exp_out(int a, int b, int c, int s);
    longint sum, q;
    sum = longint'(a) * longint'(c) + longint'(b) * longint'(s);
    q = (sum + 64'sd65536) >>> 17;
    if (q > 32767) return 32767;   // R2
    if (q < -32768) return -32768; // R2
    return int'(q);
  endfunction

  function automatic int rnd16();
    logic [15:0] r;
    r = 16'($urandom);
    return int'($signed(r));
  endfunction

  function automatic int rnd18();
    logic [17:0] r;
    r = 18'($urandom);
    return int'($signed(r));
  endfunction

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // one clock: drive at negedge, model the sample, check two edges later
  task automatic tick(int c, int s, bit v, bit [N-1:0] ld, string tag);
    cos_i       = 18'(c);
    sin_i       = 18'(s);
    smp_valid_i = v;
    coef_load_i = ld;
    for (int ch = 0; ch < N; ch++) begin
      coef_a_i[ch*16 +: 16] = 16'(na[ch]);
      coef_b_i[ch*16 +: 16] = 16'(nb[ch]);
      cur[ch] = 0;
      if (v) begin
        int ea, eb;
        ea = m_pend[ch] ? m_sh_a[ch] : m_act_a[ch];
        eb = m_pend[ch] ? m_sh_b[ch] : m_act_b[ch];
        cur[ch] = exp_out(ea, eb, c, s);
        m_act_a[ch] = ea;
        m_act_b[ch] = eb;
        m_pend[ch] = 1'b0;
      end
      if (ld[ch]) begin
        m_sh_a[ch] = na[ch];
        m_sh_b[ch] = nb[ch];
        m_pend[ch] = 1'b1;
      end
    end
    @(posedge clk_i);
    d2 = d1; d2_v = d1_v;
    d1 = cur; d1_v = v;
    @(negedge clk_i);
    if (d2_v) hold = d2;
    chk(dac_valid_o == d2_v, tag, "valid (R4)", longint'(dac_valid_o), longint'(d2_v));
    for (int ch = 0; ch < N; ch++) begin
      int act;
      act = int'($signed(dac_data_o[ch*16 +: 16]));
      chk(act == hold[ch], tag, $sformatf("ch%0d data", ch), act, hold[ch]);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #4000000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int ch = 0; ch < N; ch++) begin
      m_act_a[ch] = 0; m_act_b[ch] = 0; m_sh_a[ch] = 0; m_sh_b[ch] = 0;
      m_pend[ch] = 1'b0; na[ch] = 0; nb[ch] = 0;
      d1[ch] = 0; d2[ch] = 0; hold[ch] = 0;
    end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R7 reset state
    chk(dac_valid_o == 1'b0, "R7", "valid after reset", longint'(dac_valid_o), 0);
    chk(dac_data_o == '0, "R7", "data after reset", longint'(dac_data_o), 0);
    // R7: unloaded weights are zero
    tick(1000, -2000, 1, '0, "R7");
    tick(131071, 131071, 1, '0, "R7");
    tick(0, 0, 0, '0, "R7");
    tick(0, 0, 0, '0, "R7");

    // R1/R3: distinct pair per channel, loaded with no sample on the edge
    for (int ch = 0; ch < N; ch++) begin
      na[ch] = ch * 7000 - 25000;
      nb[ch] = 20000 - ch * 5500;
    end
    tick(0, 0, 0, '1, "R5");
    tick(50000, -30000, 1, '0, "R1");
    tick(-131072, 77, 1, '0, "R3");
    tick(0, 0, 1, '0, "R1");
    tick(3, -3, 1, '0, "R1");
    tick(0, 0, 0, '0, "R8");
    tick(0, 0, 0, '0, "R8");

    // R2: rails and saturation
    na[0] = 32767;  nb[0] = 32767;
    na[1] = -32768; nb[1] = -32768;
    na[2] = 32767;  nb[2] = 0;
    na[3] = 0;      nb[3] = 0;
    na[4] = -32768; nb[4] = 0;
    na[5] = 0;      nb[5] = -32768;
    na[6] = 32767;  nb[6] = -32768;
    na[7] = -1;     nb[7] = 1;
    tick(0, 0, 0, '1, "R2");
    tick(131071, 131071, 1, '0, "R2");
    tick(-131072, -131072, 1, '0, "R2");
    tick(131071, -131072, 1, '0, "R2");
    tick(-131072, 131071, 1, '0, "R2");

    // R5: load on the same edge as a sample, old pair still used there
    for (int ch = 0; ch < N; ch++) begin
      na[ch] = 1000 * (ch + 1);
      nb[ch] = -900 * (ch + 1);
    end
    tick(60000, 40000, 1, '1, "R5");
    tick(60000, 40000, 1, '0, "R5");
    tick(-60000, 40000, 1, '0, "R5");

    // R6: two loads between samples, last one wins
    for (int ch = 0; ch < N; ch++) begin na[ch] = 30000; nb[ch] = 30000; end
    tick(0, 0, 0, '1, "R6");
    for (int ch = 0; ch < N; ch++) begin na[ch] = -12345; nb[ch] = 23456; end
    tick(0, 0, 0, '1, "R6");
    tick(100000, -100000, 1, '0, "R6");
    tick(-5, 99999, 1, '0, "R6");

    // R9: load one channel only
    for (int ch = 0; ch < N; ch++) begin na[ch] = 32767; nb[ch] = -32768; end
    tick(0, 0, 0, 8'b0000_1000, "R9");
    tick(90000, 20000, 1, '0, "R9");
    tick(-90000, 20000, 1, '0, "R9");

    // random traffic with gaps and loads
    for (int i = 0; i < 600; i++) begin
      bit [N-1:0] ld;
      bit v;
      for (int ch = 0; ch < N; ch++) begin
        na[ch] = rnd16();
        nb[ch] = rnd16();
        ld[ch] = ($urandom % 8) == 0;
      end
      v = ($urandom % 3) != 0;
      tick(rnd18(), rnd18(), v, ld, (i % 2 == 0) ? "R3" : "R4");
    end
    tick(0, 0, 0, '0, "R8");
    tick(0, 0, 0, '0, "R8");
    finish_run();
  end
endmodule